// File: doc/BRIEF.md
# Standby Wake-Up Filter Controller

This block chooses between a normal operating mode and a low-power standby mode for a bus receiver, and produces the receive-data output seen by the local protocol controller. Its inputs are a standby request, two supply-good flags (main supply and I/O supply) and a digitised bus-dominant flag from the low-power receiver. In normal mode the receive output tracks the bus with no delay. In standby mode a wake-up filter lets only long dominant periods through, so short disturbances do not wake the system. If the bus is already dominant when standby begins, for example because of a stuck-dominant fault, the filter locks out the wake-up path until the bus has been recessive for a minimum time.

Supply failures take priority over the standby request. A failed main supply forces standby while the wake-up filter keeps running. A failed I/O supply also forces standby, turns off the receive-output enable and resets the wake-up filter. A parameter selects a variant without a wake-up receiver, which holds the receive output recessive for the whole of standby. The filter is a Moore state machine with seven states. IDLE is the state outside standby. LOCK means the bus was dominant at standby entry. CLEAR counts recessive time while locked. QUIET means standby with no wake pending. TIMING counts a dominant period. WAKE drives the output low. RELEASE counts recessive time before the output returns high. Its transitions are: enter (IDLE to LOCK or QUIET, chosen by the first bus sample), unlock start (LOCK to CLEAR), relock (CLEAR to LOCK), unlock (CLEAR to QUIET), pulse start (QUIET to TIMING), pulse drop (TIMING to QUIET), wake (TIMING to WAKE), gap start (WAKE to RELEASE, or WAKE to QUIET when the glitch length is 1), gap drop (RELEASE to WAKE), release (RELEASE to QUIET) and abort (any state to IDLE when the filter is disabled).

Top module: `stby_wake_ctrl`

## Requirements
- R1: The mode output is 0 for normal and 1 for standby. With both supplies good, a low standby input selects normal and a high standby input selects standby.
- R2: In normal mode with the I/O supply good, rxd equals the inverse of bus_dom in the same cycle, where bus_dom high means a dominant bus.
- R3: In standby, rxd goes low at the clock edge that samples the WAKE_CYC-th consecutive dominant bus_dom. A dominant run shorter than WAKE_CYC samples leaves rxd high.
- R4: After a wake, rxd stays low through recessive gaps shorter than GLITCH_CYC samples. It returns high at the edge that samples the GLITCH_CYC-th consecutive recessive value.
- R5: If the first sample in standby is dominant, rxd stays high until CLEAR_CYC consecutive recessive samples have been seen. Any dominant sample before that restarts the recessive count. After the count completes, normal wake filtering applies.
- R6: When main_ok is low and io_ok is high, mode is 2 (forced standby) whatever the standby input, and the wake filter of R3 to R5 stays active.
- R7: When io_ok is low, mode is 2, rxd_oe is 0, rxd is held at 1 and the wake filter is reset. When io_ok returns in standby, the filter starts again from entry.
- R8: A period in normal mode, even a single cycle, clears all filter and lock-out progress, so a later standby entry starts its counts from zero.
- R9: With HAS_WAKE set to 0, rxd is 1 whenever mode is not normal.
- R10: While rst_n is low the filter is idle, and rxd is 1 in standby whatever the bus state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stby_sel | input | 1 | Standby request (1 = standby) |
| main_ok | input | 1 | Main supply good |
| io_ok | input | 1 | I/O supply good |
| bus_dom | input | 1 | Bus dominant flag from the receiver (1 = dominant) |
| rxd | output | 1 | Receive data (0 = dominant) |
| rxd_oe | output | 1 | Receive output enable (0 = tri-state) |
| mode | output | 2 | 0 normal, 1 standby, 2 forced standby |

## Verification
The hardest situation to reach is the lock-out clearing path. It needs a bus that is dominant at the exact cycle of standby entry, followed by a recessive run that falls one sample short, a dominant sample that restarts the count, and then a full-length recessive run. Directed sequences hold the bus dominant across the change from normal to standby and then apply gaps of CLEAR_CYC-1 and CLEAR_CYC samples. Randomised segments that toggle mode and supplies in the middle of bursts then reach lock-out entries and aborts from many states.

// File: rtl/wk_pkg.sv
package wk_pkg;
    typedef enum logic [1:0] {
        MODE_NORMAL  = 2'd0,
        MODE_STANDBY = 2'd1,
        MODE_FORCED  = 2'd2
    } op_mode_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOCK,
        S_CLEAR,
        S_QUIET,
        S_TIMING,
        S_WAKE,
        S_RELEASE
    } wake_state_e;
endpackage

// File: rtl/wk_mode_sel.sv
module wk_mode_sel
    import wk_pkg::*;
(
    input  logic     stby_sel,
    input  logic     main_ok,
    input  logic     io_ok,
    output op_mode_e mode,
    output logic     wake_en
);
    // supply failures take priority over the request
    always_comb begin
        if (!io_ok || !main_ok) mode = MODE_FORCED;
        else if (stby_sel)      mode = MODE_STANDBY;
        else                    mode = MODE_NORMAL;
        wake_en = io_ok && (mode != MODE_NORMAL);
    end
endmodule

// File: rtl/wk_filter_fsm.sv
module wk_filter_fsm
    import wk_pkg::*;
#(
    parameter int WAKE_CYC   = 600,
    parameter int CLEAR_CYC  = 600,
    parameter int GLITCH_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wake_en,
    input  logic bus_dom,
    output logic wake_low
);
    localparam int MAX_AB = (WAKE_CYC > CLEAR_CYC) ? WAKE_CYC : CLEAR_CYC;
    localparam int MAXC   = (MAX_AB > GLITCH_CYC) ? MAX_AB : GLITCH_CYC;
    localparam int CW     = $clog2(MAXC + 1);
    localparam logic [CW-1:0] WAKE_LAST = CW'(WAKE_CYC - 1);
    localparam logic [CW-1:0] CLR_LAST  = CW'(CLEAR_CYC - 1);
    localparam logic [CW-1:0] GL_LAST   = CW'(GLITCH_CYC - 1);
    localparam logic [CW-1:0] ONE       = CW'(1);

    wake_state_e st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= S_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (!wake_en) begin
            st_d  = S_IDLE;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                S_IDLE: begin
                    st_d  = bus_dom ? S_LOCK : S_QUIET;
                    cnt_d = '0;
                end
                S_LOCK: begin
                    if (!bus_dom) begin
                        st_d  = S_CLEAR;
                        cnt_d = ONE;
                    end
                end
                S_CLEAR: begin
                    if (bus_dom) begin
                        st_d  = S_LOCK;
                        cnt_d = '0;
                    end else if (cnt_q == CLR_LAST) begin
                        st_d  = S_QUIET;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
                S_QUIET: begin
                    if (bus_dom) begin
                        st_d  = S_TIMING;
                        cnt_d = ONE;
                    end
                end
                S_TIMING: begin
                    if (!bus_dom) begin
                        st_d  = S_QUIET;
                        cnt_d = '0;
                    end else if (cnt_q == WAKE_LAST) begin
                        st_d  = S_WAKE;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
                S_WAKE: begin
                    if (!bus_dom) begin
                        if (GLITCH_CYC < 2) begin
                            st_d  = S_QUIET;
                            cnt_d = '0;
                        end else begin
                            st_d  = S_RELEASE;
                            cnt_d = ONE;
                        end
                    end
                end
                S_RELEASE: begin
                    if (bus_dom) begin
                        st_d  = S_WAKE;
                        cnt_d = '0;
                    end else if (cnt_q == GL_LAST) begin
                        st_d  = S_QUIET;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
                default: begin
                    st_d  = S_IDLE;
                    cnt_d = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (st_q)
            S_WAKE, S_RELEASE: wake_low = 1'b1;
            default:           wake_low = 1'b0;
        endcase
    end

    p_idle_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_en |=> (st_q == S_IDLE));
    p_lock_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_en && st_q == S_LOCK && bus_dom) |=> !wake_low);
    p_wake_after_dom_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_low) |-> ($past(bus_dom) && $past(wake_en)));
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(MAXC));
endmodule

// File: rtl/stby_wake_ctrl.sv
module stby_wake_ctrl
    import wk_pkg::*;
#(
    parameter int WAKE_CYC   = 600,
    parameter int CLEAR_CYC  = 600,
    parameter int GLITCH_CYC = 8,
    parameter bit HAS_WAKE   = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stby_sel,
    input  logic       main_ok,
    input  logic       io_ok,
    input  logic       bus_dom,
    output logic       rxd,
    output logic       rxd_oe,
    output logic [1:0] mode
);
    op_mode_e mode_w;
    logic     wake_en;
    logic     fsm_low;
    logic     wake_low;

    wk_mode_sel u_mode (
        .stby_sel (stby_sel),
        .main_ok  (main_ok),
        .io_ok    (io_ok),
        .mode     (mode_w),
        .wake_en  (wake_en)
    );

    wk_filter_fsm #(
        .WAKE_CYC   (WAKE_CYC),
        .CLEAR_CYC  (CLEAR_CYC),
        .GLITCH_CYC (GLITCH_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wake_en  (wake_en),
        .bus_dom  (bus_dom),
        .wake_low (fsm_low)
    );

    generate
        if (HAS_WAKE) begin : g_wake
            assign wake_low = fsm_low;
        end else begin : g_nowake
            assign wake_low = 1'b0;
            p_stby_recessive_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (mode != 2'd0) |-> rxd);
        end
    endgenerate

    always_comb begin
        mode   = mode_w;
        rxd_oe = io_ok;
        if (!io_ok)                    rxd = 1'b1;
        else if (mode_w == MODE_NORMAL) rxd = !bus_dom;
        else                           rxd = !wake_low;
    end

    p_forced_main_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !main_ok |-> (mode == 2'd2));
    p_io_blocks_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !io_ok |=> !fsm_low);
endmodule

// File: tb/sim_stby_wake_ctrl.sv
`timescale 1ns/100ps
module sim_stby_wake_ctrl;
    localparam int W = 20;
    localparam int C = 16;
    localparam int G = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stby = 1'b1, main_ok = 1'b1, io_ok = 1'b1, bus = 1'b0;
    logic rxd0, oe0, rxd1, oe1;
    logic [1:0] mode0, mode1;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference model state
    bit m_act, m_lock, m_woke;
    int m_drun, m_rrun;

    always #2.5 clk = ~clk;

    stby_wake_ctrl #(.WAKE_CYC(W), .CLEAR_CYC(C), .GLITCH_CYC(G), .HAS_WAKE(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .stby_sel(stby), .main_ok(main_ok), .io_ok(io_ok),
        .bus_dom(bus), .rxd(rxd0), .rxd_oe(oe0), .mode(mode0));

    stby_wake_ctrl #(.WAKE_CYC(W), .CLEAR_CYC(C), .GLITCH_CYC(G), .HAS_WAKE(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .stby_sel(stby), .main_ok(main_ok), .io_ok(io_ok),
        .bus_dom(bus), .rxd(rxd1), .rxd_oe(oe1), .mode(mode1));

    function automatic logic [1:0] exp_mode(logic s, logic m, logic io);
        if (!io || !m) return 2'd2;
        return s ? 2'd1 : 2'd0;
    endfunction

    function automatic logic exp_rxd(logic s, logic m, logic io, logic d, bit has_wake);
        if (!io) return 1'b1;
        if (exp_mode(s, m, io) == 2'd0) return !d;
        return has_wake ? !m_woke : 1'b1;
    endfunction

    task automatic check(string tag, string what, logic [1:0] act, logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_update(logic s, logic m, logic io, logic d);
        bit en;
        en = io && (!m || s);
        if (!en) begin
            m_act = 0; m_lock = 0; m_woke = 0; m_drun = 0; m_rrun = 0;
        end else if (!m_act) begin
            m_act = 1; m_lock = d; m_woke = 0; m_drun = 0; m_rrun = 0;
        end else if (m_lock) begin
            if (d) m_rrun = 0;
            else begin
                m_rrun++;
                if (m_rrun == C) begin m_lock = 0; m_rrun = 0; end
            end
        end else if (d) begin
            m_drun++; m_rrun = 0;
            if (m_drun == W) m_woke = 1;
        end else begin
            m_rrun++; m_drun = 0;
            if (m_rrun == G) m_woke = 0;
        end
    endtask

    task automatic step(logic s, logic m, logic io, logic d, string tag);
        @(negedge clk);
        stby = s; main_ok = m; io_ok = io; bus = d;
        #1;
        check(tag, "rxd", {1'b0, rxd0}, {1'b0, exp_rxd(s, m, io, d, 1'b1)});
        check(tag, "rxd_oe", {1'b0, oe0}, {1'b0, io});
        check(tag, "mode", mode0, exp_mode(s, m, io));
        check("R9", "rxd nowake", {1'b0, rxd1}, {1'b0, exp_rxd(s, m, io, d, 1'b0)});
        if (rst_n) model_update(s, m, io, d);
    endtask

    task automatic run(int n, logic s, logic m, logic io, logic d, string tag);
        for (int i = 0; i < n; i++) step(s, m, io, d, tag);
    endtask

    initial begin
        void'($urandom(32'd1234));
        m_act = 0; m_lock = 0; m_woke = 0; m_drun = 0; m_rrun = 0;
        // R10: reset holds filter idle, standby rxd recessive
        run(4, 1, 1, 1, 1, "R10");
        @(negedge clk); rst_n = 1'b1;
        // R1, R2: normal mode follows the bus
        run(3, 0, 1, 1, 0, "R2");
        run(2, 0, 1, 1, 1, "R2");
        step(0, 1, 1, 0, "R1");
        // R3: short dominant pulse filtered, long one passes
        run(3, 1, 1, 1, 0, "R1");
        run(W - 1, 1, 1, 1, 1, "R3");
        run(3, 1, 1, 1, 0, "R3");
        run(W + 2, 1, 1, 1, 1, "R3");
        // R4: gap shorter than glitch keeps rxd low, full gap releases
        run(G - 1, 1, 1, 1, 0, "R4");
        run(2, 1, 1, 1, 1, "R4");
        run(G + 2, 1, 1, 1, 0, "R4");
        // R5: stuck dominant at entry
        run(3, 0, 1, 1, 1, "R2");
        run(W + 10, 1, 1, 1, 1, "R5");
        run(C - 1, 1, 1, 1, 0, "R5");
        step(1, 1, 1, 1, "R5");
        run(C, 1, 1, 1, 0, "R5");
        run(W + 1, 1, 1, 1, 1, "R5");
        run(G, 1, 1, 1, 0, "R5");
        // R6: main supply loss forces standby with filter active
        run(2, 0, 0, 1, 0, "R6");
        run(W + 1, 0, 0, 1, 1, "R6");
        run(G, 0, 0, 1, 0, "R6");
        // R7: io loss tri-states and resets filter
        run(W - 2, 1, 1, 1, 1, "R7");
        run(3, 1, 1, 0, 1, "R7");
        run(W + 1, 1, 1, 1, 1, "R7");
        run(C, 1, 1, 1, 0, "R7");
        // R8: a single normal cycle clears progress
        run(W - 1, 1, 1, 1, 1, "R8");
        step(0, 1, 1, 0, "R8");
        step(1, 1, 1, 0, "R8");
        run(W - 1, 1, 1, 1, 1, "R8");
        run(2, 1, 1, 1, 0, "R8");
        // randomised segments
        for (int k = 0; k < 400; k++) begin
            int len;
            logic s, m, io, d;
            len = 1 + int'($urandom % (2 * W));
            d   = logic'($urandom % 2);
            s   = logic'(($urandom % 8) != 0);
            m   = logic'(($urandom % 12) != 0);
            io  = logic'(($urandom % 16) != 0);
            run(len, s, m, io, d, "R3");
        end
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule